// File: doc/BRIEF.md
# SDRAM Per-Bank Command Legality Checker

This block watches the command pins of a double-data-rate SDRAM interface (chip select, row strobe, column strobe, write enable) together with the bank address. It keeps a small state machine per bank and flags any command that the addressed bank cannot accept in its present state. Each bank is in one of four states: idle, row open, read burst or write burst. Auto-precharge variants are not modelled.

It sits beside a memory controller as a protocol monitor. The controller supplies a qualifier that is high only when the clock enable was high on both the previous and the current edge and any self-refresh exit delay has elapsed. It also supplies one burst-done bit per bank. Outputs are the registered command code, the packed per-bank state and a one-cycle illegal strobe. Timing parameters and data are not checked.

Top module: `sdram_bank_guard`

## Requirements
- R1: The decoded command is registered on every clock edge onto `cmd_code`. Chip select high gives 0 (deselect). Otherwise {ras_n,cas_n,we_n} maps as follows: 111 gives 1 (no-op), 011 gives 2 (activate), 101 gives 3 (read), 100 gives 4 (write), 010 gives 5 (precharge), 110 gives 6 (burst stop), 001 gives 7 (refresh) and 000 gives 8 (mode set).
- R2: Deselect and no-op are legal in every state and leave every bank's state unchanged.
- R3: An idle bank accepts activate and moves to row open (state code 1). Refresh and mode set are legal when every bank is idle and change no state.
- R4: In row open, read moves the bank to read burst (code 2), write moves it to write burst (code 3) and precharge returns it to idle (code 0).
- R5: In read burst, read restarts the burst and stays in code 2, precharge returns the bank to idle, and burst stop returns it to row open.
- R6: In write burst, write stays in code 3, read moves the bank to read burst and precharge returns it to idle.
- R7: Every other command and state pair is illegal. `illegal` is high for the one cycle after the edge that carried it, and that command changes no state.
- R8: Refresh or mode set while any bank is not idle raises `illegal`.
- R9: While `cke_ok` is low, commands change no state and never raise `illegal`.
- R10: A high `burst_done[b]` moves bank b from read or write burst to row open. A state-changing command to bank b at the same edge takes priority.
- R11: Precharge affects only the addressed bank. Bank b's state is `bank_state[2b+1:2b]`, and the bank count is a parameter (default 4).
- R12: After reset every bank is idle, `illegal` is low and `cmd_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | BW | Addressed bank |
| cke_ok | input | 1 | Clock enable high on both edges and exit delay met |
| burst_done | input | NBANK | Per-bank end-of-burst indication |
| cmd_code | output | 4 | Registered decoded command |
| bank_state | output | 2*NBANK | Packed per-bank state |
| illegal | output | 1 | Illegal-command strobe |

## Verification
A burst-done pulse and a command to the same bank can land on the same edge. The bench provokes this by raising `burst_done` for a bank in burst while issuing a precharge, and later a read, to that bank. It expects the command's target state, not row open. It also raises a burst-done bit while a command goes to a different bank, and expects both banks to move.

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard #(
  parameter int NBANK = 4,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [BW-1:0]      bank,
  input  logic               cke_ok,
  input  logic [NBANK-1:0]   burst_done,
  output logic [3:0]         cmd_code,
  output logic [2*NBANK-1:0] bank_state,
  output logic               illegal
);
  localparam logic [3:0] C_DES = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
                         C_WR = 4'd4, C_PRE = 4'd5, C_BST = 4'd6, C_REF = 4'd7, C_MRS = 4'd8;
  localparam logic [1:0] S_IDLE = 2'd0, S_OPEN = 2'd1, S_RDB = 2'd2, S_WRB = 2'd3;

  logic [3:0] dec;
  logic [1:0] st [NBANK];
  logic [1:0] cur, nxt;
  logic       legal, all_idle, moves;

  always_comb begin
    if (cs_n) dec = C_DES;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: dec = C_NOP;
        3'b011: dec = C_ACT;
        3'b101: dec = C_RD;
        3'b100: dec = C_WR;
        3'b010: dec = C_PRE;
        3'b110: dec = C_BST;
        3'b001: dec = C_REF;
        default: dec = C_MRS;
      endcase
    end
  end

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NBANK; i++)
      if (st[i] != S_IDLE) all_idle = 1'b0;
  end

  assign cur   = st[bank];
  assign moves = (dec == C_ACT) || (dec == C_RD) || (dec == C_WR) ||
                 (dec == C_PRE) || (dec == C_BST);

  always_comb begin
    legal = 1'b1;
    nxt   = cur;
    case (dec)
      C_ACT: if (cur == S_IDLE) nxt = S_OPEN; else legal = 1'b0;
      C_RD:  if (cur != S_IDLE) nxt = S_RDB;  else legal = 1'b0;
      C_WR:  if (cur == S_OPEN || cur == S_WRB) nxt = S_WRB; else legal = 1'b0;
      C_PRE: if (cur != S_IDLE) nxt = S_IDLE; else legal = 1'b0;
      C_BST: if (cur == S_RDB) nxt = S_OPEN;  else legal = 1'b0;
      C_REF, C_MRS: legal = all_idle;
      default: legal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_code <= C_DES;
      illegal  <= 1'b0;
    end else begin
      cmd_code <= dec;
      illegal  <= cke_ok && !legal;
    end
  end

  // R8
  ref_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_ok && (dec == C_REF || dec == C_MRS) && !all_idle) |=> illegal);

  // R9
  unqual_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_ok |=> !illegal);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = cke_ok && (bank == BW'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) st[b] <= S_IDLE;
      else if (hit && legal && moves) st[b] <= nxt;
      else if (burst_done[b] && (st[b] == S_RDB || st[b] == S_WRB)) st[b] <= S_OPEN;
    end

    assign bank_state[2*b +: 2] = st[b];

    // R3
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && dec == C_ACT && st[b] == S_IDLE) |=> (st[b] == S_OPEN && !illegal));

    // R11
    pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && dec == C_PRE && st[b] != S_IDLE) |=> (st[b] == S_IDLE));

    // R5
    bst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && dec == C_BST && st[b] == S_RDB) |=> (st[b] == S_OPEN));

    // R10
    done_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_done[b] && st[b] != S_IDLE && st[b] != S_OPEN && !(hit && moves))
      |=> (st[b] == S_OPEN));

    // R7
    idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[b] == S_IDLE) |=> (st[b] == S_IDLE || st[b] == S_OPEN));
  end
endmodule

// File: tb/tb_sdram_bank_guard.sv
`timescale 1ns/1ps
module tb_sdram_bank_guard;
  localparam int NB = 4;
  localparam logic [3:0] DES = 0, NOP = 1, ACT = 2, RD = 3, WR = 4, PRE = 5, BST = 6, REF = 7, MRS = 8;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] bank = 0;
  logic cke_ok = 1;
  logic [NB-1:0] burst_done = '0;
  logic [3:0] cmd_code;
  logic [2*NB-1:0] bank_state;
  logic illegal;
  int nchk = 0, nfail = 0;
  bit done = 0;

  sdram_bank_guard #(.NBANK(NB)) dut (.clk, .rst_n, .cs_n, .ras_n, .cas_n, .we_n,
    .bank, .cke_ok, .burst_done, .cmd_code, .bank_state, .illegal);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bs(input int b);
    return int'(bank_state[2*b +: 2]);
  endfunction

  task automatic issue(input logic [3:0] c, input int b, input logic q = 1, input logic [NB-1:0] bd = '0);
    @(negedge clk);
    case (c)
      DES: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      NOP: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      ACT: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      RD:  {cs_n, ras_n, cas_n, we_n} = 4'b0101;
      WR:  {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      PRE: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      BST: {cs_n, ras_n, cas_n, we_n} = 4'b0110;
      REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
    endcase
    bank = 2'(b); cke_ok = q; burst_done = bd;
    @(posedge clk); #1;
    {cs_n, ras_n, cas_n, we_n} = 4'b0111; cke_ok = 1; burst_done = '0;
  endtask

  task automatic t_reset;
    chk("R12 state", int'(bank_state), 0);
    chk("R12 illegal", int'(illegal), 0);
    chk("R12 cmd", int'(cmd_code), 0);
  endtask

  task automatic t_decode;
    for (int c = 0; c <= 8; c++) begin
      issue(4'(c), 0, 1'b0);
      chk("R1 decode", int'(cmd_code), c);
      chk("R9 no flag", int'(illegal), 0);
      chk("R9 no state", int'(bank_state), 0);
    end
  endtask

  task automatic t_idle;
    issue(ACT, 0); chk("R3 act", bs(0), 1); chk("R3 legal", int'(illegal), 0);
    issue(NOP, 0); chk("R2 nop", bs(0), 1); chk("R2 legal", int'(illegal), 0);
    issue(DES, 0); chk("R2 des", bs(0), 1); chk("R2 des legal", int'(illegal), 0);
    issue(REF, 1); chk("R8 ref busy", int'(illegal), 1); chk("R8 state", bs(0), 1);
    issue(MRS, 2); chk("R8 mrs busy", int'(illegal), 1);
    issue(PRE, 0); chk("R4 pre", bs(0), 0);
    issue(REF, 0); chk("R3 ref idle", int'(illegal), 0); chk("R3 ref state", int'(bank_state), 0);
    issue(MRS, 3); chk("R3 mrs idle", int'(illegal), 0);
  endtask

  task automatic t_rowact;
    issue(ACT, 1); issue(ACT, 2);
    issue(RD, 1); chk("R4 rd", bs(1), 2);
    issue(WR, 2); chk("R4 wr", bs(2), 3);
    issue(PRE, 1); chk("R11 pre b1", bs(1), 0); chk("R11 b2 kept", bs(2), 3);
    chk("R4 legal", int'(illegal), 0);
  endtask

  task automatic t_rdburst;
    issue(ACT, 1); issue(RD, 1);
    issue(RD, 1); chk("R5 rd again", bs(1), 2); chk("R5 legal", int'(illegal), 0);
    issue(BST, 1); chk("R5 bst", bs(1), 1);
    issue(RD, 1); issue(PRE, 1); chk("R5 pre", bs(1), 0);
  endtask

  task automatic t_wrburst;
    issue(WR, 2); chk("R6 wr again", bs(2), 3); chk("R6 legal", int'(illegal), 0);
    issue(RD, 2); chk("R6 rd", bs(2), 2);
    issue(BST, 2); issue(WR, 2); chk("R6 wr", bs(2), 3);
    issue(PRE, 2); chk("R6 pre", bs(2), 0);
  endtask

  task automatic t_illegal;
    issue(RD, 0);  chk("R7 rd idle", int'(illegal), 1); chk("R7 rd idle st", bs(0), 0);
    issue(PRE, 0); chk("R7 pre idle", int'(illegal), 1);
    issue(NOP, 0); chk("R7 strobe one cycle", int'(illegal), 0);
    issue(BST, 0); chk("R7 bst idle", int'(illegal), 1);
    issue(ACT, 0); issue(ACT, 0); chk("R7 act open", int'(illegal), 1); chk("R7 act open st", bs(0), 1);
    issue(WR, 0);  issue(BST, 0); chk("R7 bst wr", int'(illegal), 1); chk("R7 bst wr st", bs(0), 3);
    issue(RD, 0);  issue(WR, 0); chk("R7 wr in rd", int'(illegal), 1); chk("R7 wr in rd st", bs(0), 2);
    issue(ACT, 3, 1'b0); chk("R9 act unqual", bs(3), 0);
  endtask

  task automatic t_burst_done;
    issue(NOP, 0, 1'b1, 4'b0001); chk("R10 done rd", bs(0), 1);
    issue(WR, 0);
    issue(PRE, 0, 1'b1, 4'b0001); chk("R10 cmd wins pre", bs(0), 0);
    issue(ACT, 0); issue(RD, 0);
    issue(RD, 0, 1'b1, 4'b0001); chk("R10 cmd wins rd", bs(0), 2);
    issue(ACT, 1, 1'b1, 4'b0001); chk("R10 other bank b0", bs(0), 1); chk("R10 other bank b1", bs(1), 1);
    issue(NOP, 0, 1'b1, 4'b0011); chk("R10 open ignores done", bs(0), 1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    t_reset();
    t_decode();
    t_idle();
    t_rowact();
    t_rdburst();
    t_wrburst();
    t_illegal();
    t_burst_done();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule